// File: doc/BRIEF.md
# Planar Fine-Scroll Pixel Shifter

This block turns a stream of 16-bit frame-buffer words, stored with the bitplanes interleaved, into one colour index per pixel clock. A group is made of one word per active plane and covers 16 pixels. At the start of each line the block drops a chosen number of leading pixels (0 to 15). It still emits the full visible width for that line. To do this it takes one more word group than the visible width alone would need.

Three plane depths are supported: four planes for the narrow display width, and two planes or one plane for the wide one. A line-start pulse clears all buffered words. The same pulse also samples the depth and the skip count for the coming line. Words arrive on a valid/ready handshake. Pixels leave with a valid flag one cycle after the internal serialiser produces them. Palette lookup, address generation and sync timing are outside this block.

Top module: `fss_shifter`

## Requirements
- R1: After reset, and until the first line-start pulse, `word_ready_o` and `pix_valid_o` are both 0.
- R2: Word k of a group (k = 0 first) supplies bit k of every colour index formed from that group. Pixels are taken MSB first within each word. Index bits above the active plane count are 0.
- R3: `mode_i` encodes the plane depth: 2'b00 one plane, 2'b01 two planes, 2'b10 four planes. 2'b11 is treated as one plane.
- R4: Each line emits exactly `LO_PIXELS` valid pixels in four-plane depth and exactly `HI_PIXELS` in one-plane and two-plane depth, whatever the skip count.
- R5: The first pixel emitted on a line is pixel number `offset_i` (counted from the MSB) of the line's first group. Later pixels follow in order across group boundaries.
- R6: A line consumes planes × (width/16) words when the skip is 0, and planes × (width/16 + 1) words when it is not. After that, `word_ready_o` stays high, and further words are accepted and discarded without affecting the output.
- R7: Depth and skip count are sampled on the line-start pulse. Changing `mode_i` or `offset_i` later in the line has no effect on that line.
- R8: A line-start pulse discards any partial group and any pixels still pending. The cycle after the pulse has `pix_valid_o` at 0, and the new line is produced correctly.
- R9: With words offered every cycle, a line's valid pixels come out on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Plane depth select, sampled at line start |
| offset_i | input | 4 | Leading pixels to skip, sampled at line start |
| line_start_i | input | 1 | One-cycle pulse that begins a line |
| word_i | input | 16 | Frame-buffer word |
| word_valid_i | input | 1 | `word_i` is valid |
| word_ready_o | output | 1 | Block accepts `word_i` this cycle |
| pix_o | output | 4 | Colour index |
| pix_valid_o | output | 1 | `pix_o` holds a pixel of the current line |

## Verification
The assertions expect `line_start_i` to be a clean single-cycle pulse. They also expect words to be offered only in the plane order of a group, so that a taken group is always a full one. The no-gap property (R9) depends on the word stream keeping up with the pixel rate. For that reason it is checked only by the bench, which offers a word on every cycle between line starts. The bench never asserts `word_valid_i` in the line-start cycle. It changes `mode_i` and `offset_i` only between cycles, away from the clock edge.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int WORD_W     = 16;
  localparam int MAX_PLANES = 4;
  localparam int IDX_W      = $clog2(WORD_W);
  localparam int PLN_W      = $clog2(MAX_PLANES + 1);

  typedef enum logic [1:0] {
    MODE_1P  = 2'b00,
    MODE_2P  = 2'b01,
    MODE_4P  = 2'b10,
    MODE_RSV = 2'b11
  } fss_mode_e;

  typedef logic [MAX_PLANES-1:0][WORD_W-1:0] fss_group_t;

  function automatic logic [PLN_W-1:0] planes_of(fss_mode_e m);
    case (m)
      MODE_2P: planes_of = PLN_W'(2);
      MODE_4P: planes_of = PLN_W'(4);
      default: planes_of = PLN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/fss_word_fetch.sv
module fss_word_fetch
  import fss_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 active_i,
  input  logic [PLN_W-1:0]     planes_i,
  input  logic [CNT_W-1:0]     load_words_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 word_valid_i,
  output logic                 word_ready_o,
  input  logic                 take_i,
  output fss_group_t           back_o,
  output logic                 back_full_o,
  output logic                 fetch_done_o
);
  localparam int PL_IDX_W = (MAX_PLANES > 1) ? $clog2(MAX_PLANES) : 1;

  logic [CNT_W-1:0]    words_left_q;
  logic [PL_IDX_W-1:0] plane_q;
  logic                full_q;
  logic                store;
  logic                group_end;

  assign fetch_done_o = (words_left_q == '0);
  // surplus words are always taken once the line's quota is in
  assign word_ready_o = active_i & ~clear_i & (fetch_done_o | ~full_q);
  assign store        = word_ready_o & word_valid_i & ~fetch_done_o;
  assign group_end    = (PLN_W'(plane_q) == planes_i - PLN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_left_q <= '0;
      plane_q      <= '0;
      full_q       <= 1'b0;
    end else if (clear_i) begin
      words_left_q <= load_words_i;
      plane_q      <= '0;
      full_q       <= 1'b0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (store) begin
        words_left_q <= words_left_q - CNT_W'(1);
        if (group_end) begin
          plane_q <= '0;
          full_q  <= 1'b1;
        end else begin
          plane_q <= plane_q + PL_IDX_W'(1);
        end
      end
    end
  end

  for (genvar k = 0; k < MAX_PLANES; k++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      back_o[k] <= '0;
      else if (clear_i)                                 back_o[k] <= '0;
      else if (store && plane_q == PL_IDX_W'(k))        back_o[k] <= word_i;
    end
  end

  assign back_full_o = full_q;

  AST_TAKE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q) else $error("take of a partial group"); // R6
endmodule

// File: rtl/fss_pixel_ser.sv
module fss_pixel_ser
  import fss_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic [IDX_W-1:0]      start_idx_i,
  input  logic [PIX_W-1:0]      width_i,
  input  fss_group_t            back_i,
  input  logic                  back_full_i,
  input  logic                  fetch_done_i,
  output logic                  take_o,
  output logic [MAX_PLANES-1:0] pix_o,
  output logic                  pix_valid_o
);
  fss_group_t            front_q;
  logic                  front_valid_q;
  logic                  started_q;
  logic                  done_q;
  logic [IDX_W-1:0]      idx_q;
  logic [PIX_W-1:0]      cnt_q;
  logic [PIX_W-1:0]      width_q;
  logic [IDX_W-1:0]      bit_sel;
  logic [MAX_PLANES-1:0] colour;
  logic                  emit;
  logic                  last_pix;
  logic                  grp_end;

  // hold off the first pixel until a second group is ready, so the line runs gap-free
  assign emit     = front_valid_q & ~done_q & (started_q | back_full_i | fetch_done_i);
  assign last_pix = emit & (cnt_q == width_q - PIX_W'(1));
  assign grp_end  = emit & (idx_q == IDX_W'(WORD_W - 1));
  assign take_o   = ~clear_i & ~done_q & back_full_i & (~front_valid_q | (grp_end & ~last_pix));
  assign bit_sel  = IDX_W'(WORD_W - 1) - idx_q;

  for (genvar k = 0; k < MAX_PLANES; k++) begin : g_bit
    assign colour[k] = front_q[k][bit_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q       <= '0;
      front_valid_q <= 1'b0;
      started_q     <= 1'b0;
      done_q        <= 1'b0;
      idx_q         <= '0;
      cnt_q         <= '0;
      width_q       <= '0;
      pix_o         <= '0;
      pix_valid_o   <= 1'b0;
    end else if (clear_i) begin
      front_valid_q <= 1'b0;
      started_q     <= 1'b0;
      done_q        <= 1'b0;
      idx_q         <= start_idx_i;
      cnt_q         <= '0;
      width_q       <= width_i;
      pix_valid_o   <= 1'b0;
    end else begin
      pix_valid_o <= emit;
      if (emit) begin
        pix_o     <= colour;
        cnt_q     <= cnt_q + PIX_W'(1);
        idx_q     <= idx_q + IDX_W'(1);
        started_q <= 1'b1;
      end
      if (last_pix) begin
        done_q        <= 1'b1;
        front_valid_q <= 1'b0;
      end else if (take_o) begin
        front_q       <= back_i;
        front_valid_q <= 1'b1;
      end else if (grp_end) begin
        front_valid_q <= 1'b0;
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= width_q) else $error("pixel count past line width"); // R4
endmodule

// File: rtl/fss_shifter.sv
module fss_shifter
  import fss_pkg::*;
#(
  parameter int LO_PIXELS = 320,
  parameter int HI_PIXELS = 640
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            mode_i,
  input  logic [3:0]            offset_i,
  input  logic                  line_start_i,
  input  logic [WORD_W-1:0]     word_i,
  input  logic                  word_valid_i,
  output logic                  word_ready_o,
  output logic [MAX_PLANES-1:0] pix_o,
  output logic                  pix_valid_o
);
  localparam int LO_GROUPS = LO_PIXELS / WORD_W;
  localparam int HI_GROUPS = HI_PIXELS / WORD_W;
  localparam int MAX_PIX   = (LO_PIXELS > HI_PIXELS) ? LO_PIXELS : HI_PIXELS;
  localparam int MAX_GRP   = (LO_GROUPS > HI_GROUPS) ? LO_GROUPS : HI_GROUPS;
  localparam int MAX_WORDS = MAX_PLANES * (MAX_GRP + 1);
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int PIX_W     = $clog2(MAX_PIX + 1);

  fss_mode_e        mode_in;
  fss_mode_e        mode_q;
  logic             active_q;
  logic [CNT_W-1:0] groups_in;
  logic [CNT_W-1:0] load_words;
  logic [PIX_W-1:0] width_in;
  fss_group_t       back;
  logic             back_full;
  logic             fetch_done;
  logic             take;

  assign mode_in    = fss_mode_e'(mode_i);
  assign groups_in  = (mode_in == MODE_4P) ? CNT_W'(LO_GROUPS) : CNT_W'(HI_GROUPS);
  assign width_in   = (mode_in == MODE_4P) ? PIX_W'(LO_PIXELS) : PIX_W'(HI_PIXELS);
  // nonzero skip pulls one more group to refill the tail of the line
  assign load_words = CNT_W'(planes_of(mode_in)) * (groups_in + CNT_W'(offset_i != 4'd0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_1P;
      active_q <= 1'b0;
    end else if (line_start_i) begin
      mode_q   <= mode_in;
      active_q <= 1'b1;
    end
  end

  fss_word_fetch #(.CNT_W(CNT_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (line_start_i),
    .active_i     (active_q),
    .planes_i     (planes_of(mode_q)),
    .load_words_i (load_words),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .take_i       (take),
    .back_o       (back),
    .back_full_o  (back_full),
    .fetch_done_o (fetch_done)
  );

  fss_pixel_ser #(.PIX_W(PIX_W)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (line_start_i),
    .start_idx_i  (IDX_W'(offset_i)),
    .width_i      (width_in),
    .back_i       (back),
    .back_full_i  (back_full),
    .fetch_done_i (fetch_done),
    .take_o       (take),
    .pix_o        (pix_o),
    .pix_valid_o  (pix_valid_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!word_ready_o && !pix_valid_o)) else $error("activity before first line"); // R1
  AST_LINE_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> !pix_valid_o) else $error("pixel right after line start"); // R8
  AST_ONE_PLANE_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && (mode_q == MODE_1P || mode_q == MODE_RSV)) |-> (pix_o[MAX_PLANES-1:1] == '0))
    else $error("upper index bits set in one-plane depth"); // R3
  AST_TWO_PLANE_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && mode_q == MODE_2P) |-> (pix_o[MAX_PLANES-1:2] == '0))
    else $error("upper index bits set in two-plane depth"); // R2
endmodule

// File: tb/fss_shifter_test.sv
module fss_shifter_test;
  localparam int LO = 32;
  localparam int HI = 64;
  localparam int CYC_PER_LINE = 160;
  localparam int EXTRA = 3;
  localparam int NVEC = 8;
  // {mode[3:0], offset[3:0], seed[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h2011, 16'h2522, 16'h2F33, 16'h1044,
    16'h1755, 16'h0066, 16'h0F77, 16'h3388
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [1:0]  mode_i;
  logic [3:0]  offset_i;
  logic        line_start_i;
  logic [15:0] word_i;
  logic        word_valid_i;
  logic        word_ready_o;
  logic [3:0]  pix_o;
  logic        pix_valid_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  fss_shifter #(.LO_PIXELS(LO), .HI_PIXELS(HI)) uut (
    .clk_i, .rst_ni, .mode_i, .offset_i, .line_start_i,
    .word_i, .word_valid_i, .word_ready_o, .pix_o, .pix_valid_o
  );

  function automatic logic [15:0] gen_word(int seed, int idx);
    return 16'((seed * 40503) ^ (idx * 32587) ^ 4660);
  endfunction

  function automatic int planes_of(int m);
    return (m == 2) ? 4 : (m == 1) ? 2 : 1;
  endfunction

  function automatic logic [3:0] exp_pix(int mode, int off, int seed, int j);
    int planes = planes_of(mode);
    int p = off + j;
    logic [3:0] v = '0;
    for (int k = 0; k < planes; k++) begin
      logic [15:0] w = gen_word(seed, (p / 16) * planes + k);
      v[k] = w[15 - (p % 16)];
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_line(int mode, int off, int seed, bit chg, int abort_at, string req);
    int planes = planes_of(mode);
    int width  = (mode == 2) ? LO : HI;
    int need   = planes * (width / 16 + ((off != 0) ? 1 : 0));
    int total  = need + EXTRA;
    int idx = 0, npix = 0, first = -1, last = -1, extra_acc = 0, bad = 0;
    int bad_a = 0, bad_e = 0;
    @(negedge clk_i);
    mode_i = 2'(mode); offset_i = 4'(off);
    word_valid_i = 1'b0; line_start_i = 1'b1;
    @(negedge clk_i);
    line_start_i = 1'b0;
    for (int c = 0; c < CYC_PER_LINE; c++) begin
      if (c > 0) @(negedge clk_i);
      if (pix_valid_o) begin
        logic [3:0] e = exp_pix(mode, off, seed, npix);
        if (pix_o !== e && bad == 0) begin bad_a = pix_o; bad_e = e; end
        if (pix_o !== e) bad++;
        if (first < 0) first = c;
        last = c;
        npix++;
      end
      if (abort_at != 0 && c == abort_at) begin
        word_valid_i = 1'b0;
        return;
      end
      if (chg && c == 20) begin
        mode_i = ~mode_i;
        offset_i = offset_i ^ 4'hA;
      end
      word_valid_i = (idx < total);
      word_i = gen_word(seed, idx);
      #1;
      if (word_valid_i && word_ready_o) begin
        if (idx >= need) extra_acc++;
        idx++;
      end
    end
    word_valid_i = 1'b0;
    check(npix == width, req, "R4 pixels per line", npix, width);
    check(bad == 0, req, "R2/R5 pixel value", bad_a, bad_e);
    check(last - first + 1 == npix, req, "R9 gap-free span", last - first + 1, npix);
    check(extra_acc == EXTRA, req, "R6 surplus words taken", extra_acc, EXTRA);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_ni = 1'b0; mode_i = 2'd0; offset_i = 4'd0;
    line_start_i = 1'b0; word_i = '0; word_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    word_valid_i = 1'b1;
    repeat (4) @(negedge clk_i);
    // R1: idle until the first line start, even with a word offered
    check(word_ready_o == 1'b0, "R1", "ready before first line", int'(word_ready_o), 0);
    check(pix_valid_o == 1'b0, "R1", "valid before first line", int'(pix_valid_o), 0);
    word_valid_i = 1'b0;

    // R3: table covers every depth code, 2'b11 behaving as one plane
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] t = VEC[v];
      run_line(int'(t[15:12]), int'(t[11:8]), int'(t[7:0]), 1'b0, 0,
               (t[15:12] == 4'd3) ? "R3 reserved" : "R3 table");
    end

    // R7: depth and skip changed mid-line
    run_line(2, 9, 201, 1'b1, 0, "R7 four-plane");
    run_line(1, 3, 202, 1'b1, 0, "R7 two-plane");

    // R8: line restarted with a partial group held, then mid-emission
    run_line(2, 4, 203, 1'b0, 3, "R8");
    run_line(2, 11, 204, 1'b0, 0, "R8 after partial group");
    run_line(0, 6, 205, 1'b0, 30, "R8");
    run_line(0, 1, 206, 1'b0, 0, "R8 after mid-line restart");

    // R5: extreme skips on wide depth
    run_line(1, 15, 207, 1'b0, 0, "R5 skip 15");
    run_line(1, 1, 208, 1'b0, 0, "R5 skip 1");

    repeat (4) @(negedge clk_i);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule